// File: doc/BRIEF.md
# Feature Parameter Block Search Engine

This block searches the parameter list that hangs off an extended feature header in a memory-mapped register space. Given the byte address of a feature header and a search key, it first reads the header's capability word and tests the flag that says a parameter list exists. If the flag is set, it walks the parameter headers one 64-bit read at a time until it finds the requested parameter ID, reaches the last parameter, or meets a malformed link.

Each parameter header holds a forward link counted in 8-byte words, an end-of-list flag, a 16-bit version and a 16-bit ID. On the last parameter the link field holds that parameter's own size in words, not a link. On a hit the engine returns the byte address of the parameter's data, which starts in the word just after its header, together with the data size in words and the version it found. A controller uses it by pulsing a start command and waiting for the one-cycle result pulse.

Top module: `param_seek`

## Requirements
- R1: After reset, busy_o, rd_req_o and res_valid_o are all low.
- R2: A search first reads the capability word at header address + 0x20. Bit 31 of that word is the parameters-present flag. When it is clear, the search ends not-found after that single read, and offset 0x28 is never read.
- R3: When the flag is set, the first parameter header is read at header address + 0x28. Its fields are link in bits 63:35, end-of-list in bit 32, version in bits 31:16 and ID in bits 15:0. Bits 34:33 are ignored.
- R4: When a non-final header does not match, the next header is read at the current header address + link × 8.
- R5: With ver_en_i low, the first header whose ID equals key_id_i matches. With ver_en_i high, a header matches only when both its ID and its version equal the key.
- R6: On a match, res_found_o is 1 and res_addr_o is the header address + 8. res_size_o is link − 1 for a non-final header and link for the final one. res_ver_o is the header's version.
- R7: An unmatched final header, or a clear parameters-present flag, ends the search with res_found_o = 0, res_err_o = 0 and res_addr_o, res_size_o and res_ver_o all zero.
- R8: An unmatched non-final header with a zero link ends the search with res_err_o = 1 and res_found_o = 0.
- R9: rd_req_o stays high with rd_addr_o stable until rd_ack_i, and only one read is outstanding at a time. res_valid_o is a one-cycle pulse in the cycle after the final acknowledged read, and busy_o is low in that same cycle.
- R10: A start_i pulse while busy_o is high is ignored, and the search in progress completes unchanged.
- R11: The three low bits of hdr_addr_i are ignored, and every read address is 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search (taken only when idle) |
| hdr_addr_i | input | AW | Byte address of the feature header |
| key_id_i | input | 16 | Parameter ID to find |
| key_ver_i | input | 16 | Parameter version to find |
| ver_en_i | input | 1 | Require a version match as well |
| busy_o | output | 1 | Search in progress |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Byte address of the 64-bit read |
| rd_ack_i | input | 1 | Read acknowledge, with data valid |
| rd_data_i | input | 64 | Read data |
| res_valid_o | output | 1 | Result pulse |
| res_found_o | output | 1 | Parameter found |
| res_err_o | output | 1 | Zero link on a non-final header |
| res_addr_o | output | AW | Byte address of the parameter data |
| res_size_o | output | 29 | Data size in 8-byte words |
| res_ver_o | output | 16 | Version of the found parameter |

## Verification
The embedded assertions check the read handshake, the result pulse and the exclusive, zeroed result fields on every cycle: the request holding its address until acknowledged, the result pulse lasting one cycle, busy falling only together with a result, aligned read addresses, and found never set alongside error. Whether the walk visits the right addresses, picks the right match under each key mode, computes the size correctly on final and non-final headers, and ignores a start while busy can only be shown by the bench's scenarios. The bench covers these with a behavioural model that predicts the address sequence and the result, and it inserts read latency to stretch the handshake.

// File: rtl/param_seek_pkg.sv
package param_seek_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned ID_W     = 16;
  localparam int unsigned VER_W    = 16;
  localparam int unsigned LINK_W   = 29;
  localparam int unsigned CAP_OFS  = 32'h20;
  localparam int unsigned PAR_OFS  = 32'h28;
  localparam int unsigned DATA_OFS = 8;
  localparam int unsigned FLAG_BIT = 31;
  localparam int unsigned EOP_BIT  = 32;
  localparam int unsigned LINK_LSB = 35;
  localparam int unsigned VER_LSB  = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_CAP, ST_PAR} st_e;
  typedef enum logic [1:0] {V_MISS, V_HIT, V_BAD, V_HOP} verdict_e;
endpackage

// File: rtl/param_seek_decode.sv
module param_seek_decode
  import param_seek_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [ID_W-1:0]   key_id_i,
  input  logic [VER_W-1:0]  key_ver_i,
  input  logic              ver_en_i,
  output verdict_e          verdict_o,
  output logic [LINK_W-1:0] link_o,
  output logic [LINK_W-1:0] size_o,
  output logic [VER_W-1:0]  ver_o
);
  logic [LINK_W-1:0] link;
  logic              eop;
  logic [VER_W-1:0]  ver;
  logic [ID_W-1:0]   id;
  logic              hit;

  assign link = word_i[LINK_LSB +: LINK_W];
  assign eop  = word_i[EOP_BIT];
  assign ver  = word_i[VER_LSB +: VER_W];
  assign id   = word_i[ID_W-1:0];

  assign hit = (id == key_id_i) && (!ver_en_i || (ver == key_ver_i));

  always_comb begin
    if (hit)               verdict_o = V_HIT;
    else if (eop)          verdict_o = V_MISS;
    else if (link == '0)   verdict_o = V_BAD;
    else                   verdict_o = V_HOP;
  end

  // last parameter: link is the size; otherwise link spans the header word too
  assign size_o = eop ? link : link - LINK_W'(1);
  assign link_o = link;
  assign ver_o  = ver;
endmodule

// File: rtl/param_seek_ctl.sv
module param_seek_ctl
  import param_seek_pkg::*;
#(
  parameter int unsigned AW = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     hdr_addr_i,
  input  logic [ID_W-1:0]   key_id_i,
  input  logic [VER_W-1:0]  key_ver_i,
  input  logic              ver_en_i,
  input  logic              rd_ack_i,
  input  logic              flag_i,
  input  verdict_e          verdict_i,
  input  logic [LINK_W-1:0] link_i,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic [ID_W-1:0]   key_id_o,
  output logic [VER_W-1:0]  key_ver_o,
  output logic              ver_en_o,
  output logic              fin_o,
  output verdict_e          fin_kind_o
);
  localparam logic [AW-1:0] CAP_A = AW'(CAP_OFS);
  localparam logic [AW-1:0] PAR_A = AW'(PAR_OFS);

  st_e           st_q;
  logic [AW-1:0] base_q, addr_q;
  logic [AW-1:0] base_al, hop_a;

  assign base_al = {hdr_addr_i[AW-1:3], 3'b000};
  assign hop_a   = addr_q + AW'({link_i, 3'b000});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      base_q    <= '0;
      addr_q    <= '0;
      key_id_o  <= '0;
      key_ver_o <= '0;
      ver_en_o  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          base_q    <= base_al;
          addr_q    <= base_al + CAP_A;
          key_id_o  <= key_id_i;
          key_ver_o <= key_ver_i;
          ver_en_o  <= ver_en_i;
          st_q      <= ST_CAP;
        end
        ST_CAP: if (rd_ack_i) begin
          if (flag_i) begin
            addr_q <= base_q + PAR_A;
            st_q   <= ST_PAR;
          end else begin
            st_q   <= ST_IDLE;
          end
        end
        ST_PAR: if (rd_ack_i) begin
          if (verdict_i == V_HOP) addr_q <= hop_a;
          else                    st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign rd_req_o  = busy_o;
  assign rd_addr_o = addr_q;

  always_comb begin
    fin_o      = 1'b0;
    fin_kind_o = V_MISS;
    if (rd_ack_i && st_q == ST_CAP && !flag_i) begin
      fin_o = 1'b1;
    end else if (rd_ack_i && st_q == ST_PAR && verdict_i != V_HOP) begin
      fin_o      = 1'b1;
      fin_kind_o = verdict_i;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R9
  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[2:0] == 3'b000); // R11
  AST_FIN_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !busy_o); // R9
endmodule

// File: rtl/param_seek_result.sv
module param_seek_result
  import param_seek_pkg::*;
#(
  parameter int unsigned AW = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fin_i,
  input  verdict_e          kind_i,
  input  logic [AW-1:0]     hdr_a_i,
  input  logic [LINK_W-1:0] size_i,
  input  logic [VER_W-1:0]  ver_i,
  input  logic              busy_i,
  output logic              valid_o,
  output logic              found_o,
  output logic              err_o,
  output logic [AW-1:0]     addr_o,
  output logic [LINK_W-1:0] size_o,
  output logic [VER_W-1:0]  ver_o
);
  logic hit;
  assign hit = (kind_i == V_HIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      found_o <= 1'b0;
      err_o   <= 1'b0;
      addr_o  <= '0;
      size_o  <= '0;
      ver_o   <= '0;
    end else begin
      valid_o <= fin_i;
      if (fin_i) begin
        found_o <= hit;
        err_o   <= (kind_i == V_BAD);
        addr_o  <= hit ? hdr_a_i + AW'(DATA_OFS) : '0;
        size_o  <= hit ? size_i : '0;
        ver_o   <= hit ? ver_i : '0;
      end
    end
  end

  AST_RES_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R9
  AST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(found_o && err_o)); // R8
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !found_o |-> addr_o == '0 && size_o == '0 && ver_o == '0); // R7
  AST_FALL_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> valid_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_i); // R9
endmodule

// File: rtl/param_seek.sv
module param_seek
  import param_seek_pkg::*;
#(
  parameter int unsigned AW = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     hdr_addr_i,
  input  logic [ID_W-1:0]   key_id_i,
  input  logic [VER_W-1:0]  key_ver_i,
  input  logic              ver_en_i,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              res_valid_o,
  output logic              res_found_o,
  output logic              res_err_o,
  output logic [AW-1:0]     res_addr_o,
  output logic [LINK_W-1:0] res_size_o,
  output logic [VER_W-1:0]  res_ver_o
);
  verdict_e          verdict, fin_kind;
  logic [LINK_W-1:0] link, size;
  logic [VER_W-1:0]  ver, key_ver;
  logic [ID_W-1:0]   key_id;
  logic              ver_en, fin;

  param_seek_decode u_dec (
    .word_i   (rd_data_i),
    .key_id_i (key_id),
    .key_ver_i(key_ver),
    .ver_en_i (ver_en),
    .verdict_o(verdict),
    .link_o   (link),
    .size_o   (size),
    .ver_o    (ver)
  );

  param_seek_ctl #(.AW(AW)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .hdr_addr_i(hdr_addr_i),
    .key_id_i  (key_id_i),
    .key_ver_i (key_ver_i),
    .ver_en_i  (ver_en_i),
    .rd_ack_i  (rd_ack_i),
    .flag_i    (rd_data_i[FLAG_BIT]),
    .verdict_i (verdict),
    .link_i    (link),
    .busy_o    (busy_o),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .key_id_o  (key_id),
    .key_ver_o (key_ver),
    .ver_en_o  (ver_en),
    .fin_o     (fin),
    .fin_kind_o(fin_kind)
  );

  param_seek_result #(.AW(AW)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fin_i  (fin),
    .kind_i (fin_kind),
    .hdr_a_i(rd_addr_o),
    .size_i (size),
    .ver_i  (ver),
    .busy_i (busy_o),
    .valid_o(res_valid_o),
    .found_o(res_found_o),
    .err_o  (res_err_o),
    .addr_o (res_addr_o),
    .size_o (res_size_o),
    .ver_o  (res_ver_o)
  );
endmodule

// File: tb/param_seek_tb.sv
module param_seek_tb;
  localparam int AW = 48;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] hdr_addr_i = '0;
  logic [15:0]   key_id_i = '0, key_ver_i = '0;
  logic          ver_en_i = 1'b0;
  logic          busy_o, rd_req_o, rd_ack_i = 1'b0;
  logic [AW-1:0] rd_addr_o, res_addr_o;
  logic [63:0]   rd_data_i = '0;
  logic          res_valid_o, res_found_o, res_err_o;
  logic [28:0]   res_size_o;
  logic [15:0]   res_ver_o;

  param_seek #(.AW(AW)) u_dut (.*);

  always #10 clk_i = ~clk_i;

  logic [63:0]   mem [logic [AW-1:0]];
  logic [AW-1:0] exp_q [$];
  logic          e_found, e_err, active = 1'b0, res_due = 1'b0, mon_on = 1'b0;
  logic [AW-1:0] e_addr;
  logic [28:0]   e_size;
  logic [15:0]   e_ver;
  int            lat = 0, waitc = 0, n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [63:0] rd(logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] ph(int link, bit eop, int ver, int id);
    return {29'(link), 2'b00, eop, 16'(ver), 16'(id)};
  endfunction

  // behavioural model of a whole walk
  task automatic model(logic [AW-1:0] hdr, logic [15:0] kid, logic [15:0] kver, bit ven);
    logic [AW-1:0] base = {hdr[AW-1:3], 3'b000};
    logic [AW-1:0] cur;
    logic [63:0] w;
    exp_q.delete();
    e_found = 0; e_err = 0; e_addr = 0; e_size = 0; e_ver = 0;
    exp_q.push_back(base + 48'h20);
    if (!rd(base + 48'h20)[31]) return;
    cur = base + 48'h28;
    for (int i = 0; i < 256; i++) begin
      exp_q.push_back(cur);
      w = rd(cur);
      if (w[15:0] == kid && (!ven || w[31:16] == kver)) begin
        e_found = 1; e_addr = cur + 8; e_ver = w[31:16];
        e_size = w[32] ? w[63:35] : w[63:35] - 1;
        return;
      end
      if (w[32]) return;
      if (w[63:35] == 0) begin e_err = 1; return; end
      cur = cur + {16'h0, w[63:35], 3'b000};
    end
  endtask

  task automatic search(logic [AW-1:0] hdr, int kid, int kver, bit ven, int l);
    @(negedge clk_i); #2;
    lat = l;
    hdr_addr_i = hdr; key_id_i = 16'(kid); key_ver_i = 16'(kver); ver_en_i = ven;
    start_i = 1'b1;
    model(hdr, 16'(kid), 16'(kver), ven);
    active = 1'b1;
    @(negedge clk_i); #2;
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (active || res_due) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // per-cycle comparison and memory responder
  always @(negedge clk_i) if (mon_on) begin
    cmp("R9 busy", 64'(busy_o), 64'(active));
    if (res_due) begin
      cmp("R9 valid", 64'(res_valid_o), 64'd1);
      cmp("R6 found", 64'(res_found_o), 64'(e_found));
      cmp("R8 err", 64'(res_err_o), 64'(e_err));
      cmp("R6 addr", 64'(res_addr_o), 64'(e_addr));
      cmp("R6 size", 64'(res_size_o), 64'(e_size));
      cmp("R5 ver", 64'(res_ver_o), 64'(e_ver));
      res_due = 1'b0;
    end else begin
      cmp("R9 no valid", 64'(res_valid_o), 64'd0);
    end
    rd_ack_i = 1'b0;
    if (rd_req_o) begin
      if (exp_q.size() == 0) begin
        cmp("R2 extra read", 64'(rd_addr_o), 64'h0 - 1);
      end else if (waitc >= lat) begin
        cmp("R4 rd addr", 64'(rd_addr_o), 64'(exp_q[0]));
        void'(exp_q.pop_front());
        rd_ack_i = 1'b1;
        rd_data_i = rd(rd_addr_o);
        waitc = 0;
        if (exp_q.size() == 0) begin active = 1'b0; res_due = 1'b1; end
      end else begin
        waitc++;
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    cmp("R1 busy", 64'(busy_o), 0);
    cmp("R1 req", 64'(rd_req_o), 0);
    cmp("R1 valid", 64'(res_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    mon_on = 1'b1;

    // R2: flag clear -> single read, not found
    mem[48'h1020] = 64'h0;
    mem[48'h1028] = ph(1, 1, 0, 5);
    search(48'h1000, 5, 0, 0, 0); wait_done();

    // chain at 0x2000: id7 v1 (link 3), id9 v2 (link 2), id7 v4 (link 5), id12 v3 eop size 6
    mem[48'h2020] = 64'h8000_0000;
    mem[48'h2028] = ph(3, 0, 1, 7);
    mem[48'h2040] = ph(2, 0, 2, 9);
    mem[48'h2050] = ph(5, 0, 4, 7);
    mem[48'h2078] = ph(6, 1, 3, 12);
    search(48'h2000, 7, 0, 0, 0); wait_done();      // R3 R6 first header hit
    search(48'h2000, 9, 0, 0, 2); wait_done();      // R4 hop with latency
    search(48'h2000, 7, 4, 1, 1); wait_done();      // R5 version picks third
    search(48'h2000, 7, 4, 0, 0); wait_done();      // R5 id-only picks first
    search(48'h2000, 12, 0, 0, 3); wait_done();     // R6 eop size = link
    search(48'h2000, 33, 0, 0, 0); wait_done();     // R7 miss at eop
    search(48'h2005, 9, 2, 1, 0); wait_done();      // R11 low bits ignored

    // R3: reserved bits set still decode
    mem[48'h3020] = 64'h8000_0000;
    mem[48'h3028] = ph(4, 1, 8, 21) | 64'h6_0000_0000;
    search(48'h3000, 21, 8, 1, 0); wait_done();

    // R8: zero link on non-final header
    mem[48'h4020] = 64'hFFFF_FFFF;
    mem[48'h4028] = ph(0, 0, 1, 2);
    search(48'h4000, 3, 0, 0, 0); wait_done();

    // R10: start while busy ignored
    search(48'h2000, 12, 0, 0, 4);
    @(negedge clk_i); #2;
    hdr_addr_i = 48'h4000; key_id_i = 16'd2; start_i = 1'b1;
    @(negedge clk_i); #2;
    start_i = 1'b0;
    wait_done();

    // R4: large link spanning many words
    mem[48'h5020] = 64'h8000_0000;
    mem[48'h5028] = ph(200, 0, 0, 1);
    mem[48'h5668] = ph(2, 1, 9, 40);
    search(48'h5000, 40, 9, 1, 1); wait_done();

    finish_run();
  end
endmodule